// File: doc/BRIEF.md
# Stop-Mode Clock Loss Supervisor

This block decides how the device reacts when the oscillator clock fails while the device sits in a low-power stop state. It runs on an always-on supervisor clock. It receives a clock-monitor failure level, the raw oscillator clock, and asynchronous wakeup and external-reset requests. It drives the regulator, PLL and self-clock-mode enables, a sticky recovery flag with its interrupt, a stop-exit strobe, the system clock select, and two reset pulses.

Three static policy bits select the reaction to a clock loss:

- **Ignore it.**
- **Reset at once** with a monitor-reset pulse.
- **Run self-clock recovery.** The supervisor powers the backup clock path and re-qualifies the oscillator by counting a programmable number of good oscillator rising edges (4096 by default). It then either powers everything down again and remains stopped, or leaves stop on the PLL clock and returns to the oscillator once it qualifies.

The failure level, the oscillator and the two requests pass through two-flop synchronizers before any use.

Top module: `stop_clk_sup`

## Requirements
- R1: With `cfg_mon_en`=0, an oscillator failure during stop produces no reaction. The state stays `vreg_en`=0 and `scm_flag`=0, and no `stop_exit` or `cm_reset` pulse occurs.
- R2: With `cfg_mon_en`=1 and `cfg_scm_en`=0, a failure during stop produces exactly one `cm_reset` pulse and returns the block to run (`vreg_en`=1, `pll_en`=0, `scm_active`=0), with no `stop_exit`.
- R3: With `cfg_mon_en`=1 and `cfg_scm_en`=1, a failure during stop sets `vreg_en`, `pll_en`, `scm_active` and `scm_flag` to 1. With `cfg_scm_ie`=0, the block stays stopped with no `stop_exit`.
- R4: Qualification passes only after the failure level has been low for `QUAL_CYCLES` consecutive oscillator rising edges. A failure that reappears before then restarts the count from zero.
- R5: A pass while stopped in self-clock mode drops `scm_active`, then `pll_en` one cycle later, then `vreg_en` one cycle after that, with no `stop_exit`.
- R6: While the oscillator stays failed, self-clock mode remains active indefinitely.
- R7: With `cfg_scm_ie`=1, setting the flag raises `scm_irq`. The block then leaves stop with one `stop_exit` pulse in self-clock mode, with `sysclk_sel`=1 (1 selects the PLL, 0 the oscillator).
- R8: A wakeup request in stop exits with `sysclk_sel`=0 if no recovery is in progress. During self-clock recovery, it exits with `sysclk_sel`=1 and `scm_active`=1.
- R9: An external reset request used as the stop exit also gives one `rst_seq_start` pulse, whichever clock is selected.
- R10: `scm_flag` stays set after self-clock mode ends and clears only when `flag_clr` is pulsed.
- R11: After an exit in self-clock mode, a qualification pass returns `sysclk_sel` to 0 with `scm_active`=0 and `pll_en`=0.
- R12: `stop_exit`, `cm_reset` and `rst_seq_start` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on supervisor clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mon_en | input | 1 | Enable clock-loss detection |
| cfg_scm_en | input | 1 | Enable self-clock recovery instead of reset |
| cfg_scm_ie | input | 1 | Enable the recovery interrupt |
| cm_fail_async | input | 1 | Clock-monitor failure level, asynchronous |
| osc_clk | input | 1 | Oscillator clock, sampled as data |
| wake_req_async | input | 1 | Wakeup interrupt request, asynchronous |
| ext_rst_async | input | 1 | External reset request, asynchronous |
| stop_req | input | 1 | Request to enter stop from run |
| flag_clr | input | 1 | Clear pulse for the recovery flag |
| vreg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | PLL enable |
| scm_active | output | 1 | Self-clock mode active |
| scm_flag | output | 1 | Sticky recovery flag |
| scm_irq | output | 1 | Recovery interrupt request |
| stop_exit | output | 1 | One-cycle stop-exit strobe |
| sysclk_sel | output | 1 | System clock select, 1 = PLL |
| cm_reset | output | 1 | One-cycle monitor-reset request |
| rst_seq_start | output | 1 | One-cycle reset-sequence start |

## Verification
The bench sweeps all eight policy combinations against one failure during stop. This separates the ignore, immediate-reset, silent-recovery and interrupting-recovery reactions by their enables and pulses.

Beyond the sweep, the bench:
- ends stop in three ways: a wakeup with a healthy oscillator, a wakeup or external reset while the oscillator is still down, and an external reset with no failure. These distinguish the oscillator and PLL exits and whether the reset sequence fires.
- uses a failure glitch in the middle of qualification to tell a restarting counter from one that merely pauses.
- times the power-down edges to confirm their order.

// File: rtl/stop_clk_sup_pkg.sv
package stop_clk_sup_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_STOP     = 3'd1,
    ST_STOP_SCM = 3'd2,
    ST_RUN_SCM  = 3'd3,
    ST_OFF_SCM  = 3'd4,
    ST_OFF_PLL  = 3'd5
  } sup_state_e;

  typedef struct packed {
    logic vreg;
    logic pll;
    logic scm;
    logic sel;
  } pwr_out_t;

  function automatic pwr_out_t decode_pwr(sup_state_e s);
    pwr_out_t o;
    o = '0;
    case (s)
      ST_RUN:      o = '{vreg: 1'b1, pll: 1'b0, scm: 1'b0, sel: 1'b0};
      ST_STOP:     o = '{vreg: 1'b0, pll: 1'b0, scm: 1'b0, sel: 1'b0};
      ST_STOP_SCM: o = '{vreg: 1'b1, pll: 1'b1, scm: 1'b1, sel: 1'b1};
      ST_RUN_SCM:  o = '{vreg: 1'b1, pll: 1'b1, scm: 1'b1, sel: 1'b1};
      ST_OFF_SCM:  o = '{vreg: 1'b1, pll: 1'b1, scm: 1'b0, sel: 1'b0};
      ST_OFF_PLL:  o = '{vreg: 1'b1, pll: 1'b0, scm: 1'b0, sel: 1'b0};
      default:     o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sup_qual_cnt.sv
module sup_qual_cnt #(
  parameter int QUAL_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic fail_s,
  input  logic osc_s,
  output logic pass
);
  localparam int CW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic          osc_q;
  logic          osc_rise;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) osc_q <= 1'b0;
    else     osc_q <= osc_s;
  end

  assign osc_rise = osc_s & ~osc_q;

  always_ff @(posedge clk) begin
    if (rst || !active || fail_s) begin
      cnt_q <= '0;
    end else if (osc_rise) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign pass = active & ~fail_s & osc_rise & (cnt_q == LAST);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import stop_clk_sup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_mon_en,
  input  logic cfg_scm_en,
  input  logic cfg_scm_ie,
  input  logic fail_s,
  input  logic wake_s,
  input  logic ext_s,
  input  logic stop_req,
  input  logic flag_clr,
  input  logic qual_pass,
  output logic qual_active,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_active,
  output logic scm_flag,
  output logic scm_irq,
  output logic stop_exit,
  output logic sysclk_sel,
  output logic cm_reset,
  output logic rst_seq_start
);
  sup_state_e state_q, state_d;
  logic       exit_d, rseq_d, cmr_d, flag_d, flag_set;
  pwr_out_t   pwr_d;

  always_comb begin
    state_d = state_q;
    exit_d  = 1'b0;
    rseq_d  = 1'b0;
    cmr_d   = 1'b0;
    case (state_q)
      ST_RUN: if (stop_req) state_d = ST_STOP;
      ST_STOP: begin
        if (cfg_mon_en && fail_s) begin
          if (cfg_scm_en) state_d = ST_STOP_SCM;
          else begin
            state_d = ST_RUN;
            cmr_d   = 1'b1;
          end
        end else if (ext_s) begin
          state_d = ST_RUN;
          exit_d  = 1'b1;
          rseq_d  = 1'b1;
        end else if (wake_s) begin
          state_d = ST_RUN;
          exit_d  = 1'b1;
        end
      end
      ST_STOP_SCM: begin
        if (ext_s) begin
          state_d = ST_RUN_SCM;
          exit_d  = 1'b1;
          rseq_d  = 1'b1;
        end else if (wake_s || (scm_flag && cfg_scm_ie)) begin
          state_d = ST_RUN_SCM;
          exit_d  = 1'b1;
        end else if (qual_pass) begin
          state_d = ST_OFF_SCM;
        end
      end
      ST_RUN_SCM: if (qual_pass) state_d = ST_RUN;
      ST_OFF_SCM: state_d = ST_OFF_PLL;
      ST_OFF_PLL: state_d = ST_STOP;
      default:    state_d = ST_RUN;
    endcase
  end

  assign flag_set = (state_q == ST_STOP) && (state_d == ST_STOP_SCM);
  assign flag_d   = flag_set ? 1'b1 : (flag_clr ? 1'b0 : scm_flag);
  assign pwr_d    = decode_pwr(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_RUN;
      vreg_en       <= 1'b1;
      pll_en        <= 1'b0;
      scm_active    <= 1'b0;
      sysclk_sel    <= 1'b0;
      scm_flag      <= 1'b0;
      scm_irq       <= 1'b0;
      stop_exit     <= 1'b0;
      cm_reset      <= 1'b0;
      rst_seq_start <= 1'b0;
    end else begin
      state_q       <= state_d;
      vreg_en       <= pwr_d.vreg;
      pll_en        <= pwr_d.pll;
      scm_active    <= pwr_d.scm;
      sysclk_sel    <= pwr_d.sel;
      scm_flag      <= flag_d;
      scm_irq       <= flag_d & cfg_scm_ie;
      stop_exit     <= exit_d;
      cm_reset      <= cmr_d;
      rst_seq_start <= rseq_d;
    end
  end

  assign qual_active = (state_q == ST_STOP_SCM) || (state_q == ST_RUN_SCM);
endmodule

// File: rtl/stop_clk_sup.sv
module stop_clk_sup #(
  parameter int QUAL_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_mon_en,
  input  logic cfg_scm_en,
  input  logic cfg_scm_ie,
  input  logic cm_fail_async,
  input  logic osc_clk,
  input  logic wake_req_async,
  input  logic ext_rst_async,
  input  logic stop_req,
  input  logic flag_clr,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_active,
  output logic scm_flag,
  output logic scm_irq,
  output logic stop_exit,
  output logic sysclk_sel,
  output logic cm_reset,
  output logic rst_seq_start
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic             qual_active, qual_pass;

  assign raw_in = {ext_rst_async, wake_req_async, osc_clk, cm_fail_async};

  sup_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(syn_in)
  );

  sup_qual_cnt #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .active(qual_active), .fail_s(syn_in[0]),
    .osc_s(syn_in[1]), .pass(qual_pass)
  );

  sup_fsm u_fsm (
    .clk(clk), .rst(rst),
    .cfg_mon_en(cfg_mon_en), .cfg_scm_en(cfg_scm_en), .cfg_scm_ie(cfg_scm_ie),
    .fail_s(syn_in[0]), .wake_s(syn_in[2]), .ext_s(syn_in[3]),
    .stop_req(stop_req), .flag_clr(flag_clr), .qual_pass(qual_pass),
    .qual_active(qual_active),
    .vreg_en(vreg_en), .pll_en(pll_en), .scm_active(scm_active),
    .scm_flag(scm_flag), .scm_irq(scm_irq), .stop_exit(stop_exit),
    .sysclk_sel(sysclk_sel), .cm_reset(cm_reset), .rst_seq_start(rst_seq_start)
  );
endmodule

// File: rtl/stop_clk_sup_chk.sv
module stop_clk_sup_chk (
  input logic clk,
  input logic rst,
  input logic cfg_mon_en,
  input logic cfg_scm_en,
  input logic vreg_en,
  input logic pll_en,
  input logic scm_active,
  input logic scm_flag,
  input logic scm_irq,
  input logic stop_exit,
  input logic cm_reset,
  input logic rst_seq_start
);
  // R2: a monitor reset only under the reset-at-once policy
  assert_cmrst_policy_R2: assert property (@(posedge clk) disable iff (rst)
    cm_reset |-> $past(cfg_mon_en && !cfg_scm_en));

  // R1, R3: the flag rises only when detection and recovery are both enabled
  assert_flag_policy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(scm_flag) |-> $past(cfg_mon_en && cfg_scm_en));

  // R5: self-clock mode needs the PLL, and the PLL needs the regulator
  assert_scm_needs_pll_R5: assert property (@(posedge clk) disable iff (rst)
    scm_active |-> (pll_en && vreg_en));
  assert_pll_needs_vreg_R5: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> vreg_en);

  // R7: the interrupt is never raised without the flag
  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    scm_irq |-> scm_flag);

  // R9: a reset sequence starts only together with a stop exit
  assert_rseq_exit_R9: assert property (@(posedge clk) disable iff (rst)
    rst_seq_start |-> stop_exit);

  // R12: single-cycle pulses
  assert_exit_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    stop_exit |=> !stop_exit);
  assert_cmrst_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    cm_reset |=> !cm_reset);
  assert_rseq_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rst_seq_start |=> !rst_seq_start);
endmodule

bind stop_clk_sup stop_clk_sup_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mon_en(cfg_mon_en), .cfg_scm_en(cfg_scm_en),
  .vreg_en(vreg_en), .pll_en(pll_en), .scm_active(scm_active),
  .scm_flag(scm_flag), .scm_irq(scm_irq), .stop_exit(stop_exit),
  .cm_reset(cm_reset), .rst_seq_start(rst_seq_start)
);

// File: tb/sim_stop_clk_sup.sv
`timescale 1ns/1ps
module sim_stop_clk_sup;
  localparam int QUAL = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_mon_en = 0, cfg_scm_en = 0, cfg_scm_ie = 0;
  logic cm_fail_async = 0, osc_clk = 0, wake_req_async = 0, ext_rst_async = 0;
  logic stop_req = 0, flag_clr = 0;
  logic vreg_en, pll_en, scm_active, scm_flag, scm_irq;
  logic stop_exit, sysclk_sel, cm_reset, rst_seq_start;

  int n_tests = 0, n_fail = 0;
  int n_exit = 0, n_cmr = 0, n_rseq = 0;
  int cyc = 0, t_scm = 0, t_pll = 0, t_vreg = 0;
  logic osc_run = 0;
  logic [1:0] osc_div = '0;
  logic p_scm = 0, p_pll = 0, p_vreg = 0;

  always #10 clk = ~clk;

  stop_clk_sup #(.QUAL_CYCLES(QUAL)) u0 (
    .clk(clk), .rst(rst), .cfg_mon_en(cfg_mon_en), .cfg_scm_en(cfg_scm_en),
    .cfg_scm_ie(cfg_scm_ie), .cm_fail_async(cm_fail_async), .osc_clk(osc_clk),
    .wake_req_async(wake_req_async), .ext_rst_async(ext_rst_async),
    .stop_req(stop_req), .flag_clr(flag_clr), .vreg_en(vreg_en), .pll_en(pll_en),
    .scm_active(scm_active), .scm_flag(scm_flag), .scm_irq(scm_irq),
    .stop_exit(stop_exit), .sysclk_sel(sysclk_sel), .cm_reset(cm_reset),
    .rst_seq_start(rst_seq_start)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (stop_exit)     n_exit <= n_exit + 1;
      if (cm_reset)      n_cmr  <= n_cmr + 1;
      if (rst_seq_start) n_rseq <= n_rseq + 1;
    end
  end

  always @(negedge clk) begin
    if (osc_run) begin
      osc_div <= osc_div + 1'b1;
      osc_clk <= osc_div[1];
    end
    if (p_scm && !scm_active) t_scm  = cyc;
    if (p_pll && !pll_en)     t_pll  = cyc;
    if (p_vreg && !vreg_en)   t_vreg = cyc;
    p_scm = scm_active; p_pll = pll_en; p_vreg = vreg_en;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] cfg);
    @(negedge clk);
    rst = 1; cm_fail_async = 0; wake_req_async = 0; ext_rst_async = 0;
    osc_run = 0; stop_req = 0; flag_clr = 0;
    {cfg_mon_en, cfg_scm_en, cfg_scm_ie} = cfg;
    wait_cyc(3);
    n_exit = 0; n_cmr = 0; n_rseq = 0;
    rst = 0;
    wait_cyc(2);
  endtask

  task automatic enter_stop();
    stop_req = 1; wait_cyc(1); stop_req = 0; wait_cyc(4);
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(3'b000);
    check("reset vreg", vreg_en, 1);
    check("reset pll", pll_en, 0);
    check("reset scm", scm_active, 0);
    check("reset flag", scm_flag, 0);
    check("reset sel", sysclk_sel, 0);

    // Sweep all eight policy combinations
    for (int c = 0; c < 8; c++) begin
      do_reset(c[2:0]);
      enter_stop();
      check("stop vreg off", vreg_en, 0);
      cm_fail_async = 1;
      wait_cyc(10);
      if (!c[2]) begin
        check("R1 vreg", vreg_en, 0);
        check("R1 flag", scm_flag, 0);
        check("R1 exit", n_exit, 0);
        check("R1 cmr", n_cmr, 0);
        wake_req_async = 1; wait_cyc(6);
        check("R8 exit osc good", n_exit, 1);
        check("R8 sel osc", sysclk_sel, 0);
        check("R8 vreg run", vreg_en, 1);
      end else if (!c[1]) begin
        check("R2 cmr count", n_cmr, 1);
        check("R2 vreg", vreg_en, 1);
        check("R2 pll", pll_en, 0);
        check("R2 scm", scm_active, 0);
        check("R2 exit", n_exit, 0);
        check("R12 cmr single", n_cmr, 1);
      end else if (!c[0]) begin
        check("R3 vreg", vreg_en, 1);
        check("R3 pll", pll_en, 1);
        check("R3 scm", scm_active, 1);
        check("R3 flag", scm_flag, 1);
        check("R3 no exit", n_exit, 0);
        check("R3 irq", scm_irq, 0);
        wait_cyc(300);
        check("R6 scm persists", scm_active, 1);
        check("R6 no exit", n_exit, 0);
        ext_rst_async = 1; wait_cyc(6);
        check("R9 exit", n_exit, 1);
        check("R9 rseq", n_rseq, 1);
        check("R8 sel pll", sysclk_sel, 1);
        check("R8 scm kept", scm_active, 1);
        ext_rst_async = 0;
        cm_fail_async = 0; osc_run = 1;
        wait_cyc(QUAL * 4 + 30);
        check("R11 sel osc", sysclk_sel, 0);
        check("R11 scm off", scm_active, 0);
        check("R11 pll off", pll_en, 0);
        check("R12 exit single", n_exit, 1);
      end else begin
        check("R7 irq", scm_irq, 1);
        check("R7 exit", n_exit, 1);
        check("R7 sel pll", sysclk_sel, 1);
        check("R7 scm", scm_active, 1);
        check("R7 no rseq", n_rseq, 0);
      end
    end

    // Recovery while stopped, with a failure glitch restarting the count
    do_reset(3'b110);
    enter_stop();
    cm_fail_async = 1; wait_cyc(8);
    cm_fail_async = 0; osc_run = 1;
    wait_cyc(40);
    cm_fail_async = 1; wait_cyc(4); cm_fail_async = 0;
    wait_cyc(50);
    check("R4 restart no pass", scm_active, 1);
    wait_cyc(60);
    check("R4 pass scm off", scm_active, 0);
    check("R5 pll off", pll_en, 0);
    check("R5 vreg off", vreg_en, 0);
    check("R5 stays stopped", n_exit, 0);
    check("R5 pll after scm", t_pll - t_scm, 1);
    check("R5 vreg after pll", t_vreg - t_pll, 1);
    check("R10 flag sticky", scm_flag, 1);
    flag_clr = 1; wait_cyc(1); flag_clr = 0; wait_cyc(2);
    check("R10 flag cleared", scm_flag, 0);
    wake_req_async = 1; wait_cyc(6);
    check("R8 exit after recovery", n_exit, 1);
    check("R8 sel osc after recovery", sysclk_sel, 0);
    check("R8 no rseq", n_rseq, 0);

    // External reset exit without failure
    do_reset(3'b100);
    enter_stop();
    ext_rst_async = 1; wait_cyc(10);
    check("R9 plain exit", n_exit, 1);
    check("R9 plain rseq", n_rseq, 1);
    check("R9 plain sel osc", sysclk_sel, 0);
    ext_rst_async = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule